// File: doc/BRIEF.md
# Redial Digit Memory Controller

This block keeps the most recently dialed number of a telephone dialer so that it can be sent again or shown on a display. It receives decoded key codes with a valid strobe, the hook state, a flag from the dial sequencer that says a dialing sequence is still running, and a level that allows flash entries to be recorded. Digits, star, hash, pause marks, pulse-to-tone marks and, when recording is allowed, flash marks are written in key order into a 32-entry buffer of 4-bit codes.

The redial/pause key has two meanings. It asks for a redial only when it is the first key accepted after the line goes off-hook. In any other position it records a pause mark. A redial sends the stored entries to the downstream dial sequencer in order over a ready/valid handshake. The sequencer turns a pause code into a 3.6 s gap, whether the number is dialed by hand, redialed or dialed from memory. A check mode exposes the buffer through a combinational display read port, sixteen positions per group. The number can be any length, but a number longer than the buffer disables redial until a new number is started. The buffer and its overflow state persist across on-hook periods.

Top module: `redial_mem_ctrl`

## Requirements
- R1: After reset, `out_valid` and `chk_active` are 0, `chk_group` is 0, and every display position reads 15 (empty).
- R2: `key_code` values 0 to 9 (digits), 10 (star) and 11 (hash) are stored with the same code. Key 13 (pulse-to-tone) is stored as entry code 13. Entries fill positions 0, 1, 2, … in the order the keys are accepted.
- R3: Key 12 (redial/pause) that is the first key accepted after off-hook starts a replay when the buffer is non-empty and not overflowed. It does not change the buffer. `out_valid` rises one cycle after the key is accepted.
- R4: Key 12 in any later position stores entry code 12 (pause).
- R5: Key 14 (flash) stores entry code 14 only while `store_mode` is 1. While `store_mode` is 0 it stores nothing.
- R6: The first storing key after an off-hook transition discards the old contents. That entry goes to position 0 and the overflow state is cleared.
- R7: Storing more than 32 entries keeps the first 32 and sets overflow. While overflow is set, a first-key redial sends nothing.
- R8: The replay presents the entries in stored order. `out_code` stays stable while `out_valid` is high and `out_ready` is low. One entry moves per cycle with both high. `out_valid` falls after the last entry is transferred.
- R9: Keys are ignored while `off_hook` is 0, in the cycle `off_hook` first reads 1, and while a replay is running.
- R10: The buffer and the overflow state survive on-hook periods and are cleared only by reset.
- R11: Key 15 (check) with `seq_busy` at 0 enters check mode at group 0. With `seq_busy` at 1 it is ignored. In check mode each accepted key advances the group, a key in the last group leaves check mode, and no key is stored or triggers a redial.
- R12: `disp_code` returns the entry at position `chk_group`*16 + `disp_idx` when that position has been written since the last discard, and returns 15 otherwise.
- R13: `off_hook` going to 0 ends a running replay and leaves check mode. `out_valid` is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| off_hook | input | 1 | Line state, 1 = off-hook |
| seq_busy | input | 1 | Dial sequencer still executing a sequence |
| store_mode | input | 1 | Allows flash keys to be recorded |
| key_valid | input | 1 | One-cycle strobe for `key_code` |
| key_code | input | 4 | Decoded key (0-11 dial keys, 12 redial/pause, 13 pulse-to-tone, 14 flash, 15 check) |
| out_valid | output | 1 | Replay entry available |
| out_ready | input | 1 | Sequencer accepts the entry |
| out_code | output | 4 | Replayed entry code |
| chk_active | output | 1 | Check mode active |
| chk_group | output | 1 | Displayed group of sixteen positions |
| disp_idx | input | 4 | Position inside the displayed group |
| disp_code | output | 4 | Entry at the addressed position, 15 if empty |

## Verification
The assertions assume that `key_valid` pulses last one cycle, that `out_ready` is driven only from the sequencer side, and that `off_hook` is a settled, debounced level. The stall-stability property also assumes that a running replay is ended only by hook changes. The stimulus drives every input at the falling clock edge and holds each key strobe for exactly one cycle. It toggles the hook with gaps of at least two cycles and varies `out_ready` in a fixed pattern that includes stalls. Keys are injected during a replay and during check mode only to show that they are ignored.

// File: rtl/redial_pkg.sv
package redial_pkg;
  typedef logic [3:0] code_t;

  localparam code_t ENT_HASH  = 4'd11;
  localparam code_t ENT_PAUSE = 4'd12;
  localparam code_t ENT_TONE  = 4'd13;
  localparam code_t ENT_FLASH = 4'd14;
  localparam code_t ENT_EMPTY = 4'd15;

  localparam code_t KEY_RP    = 4'd12;
  localparam code_t KEY_TONE  = 4'd13;
  localparam code_t KEY_FLASH = 4'd14;
  localparam code_t KEY_CHECK = 4'd15;

  typedef enum logic [1:0] {ACT_NONE, ACT_STORE, ACT_REDIAL, ACT_CHECK} act_e;

  function automatic logic is_dial_key(input code_t k);
    return k <= ENT_HASH;
  endfunction
endpackage

// File: rtl/redial_keyclass.sv
module redial_keyclass
  import redial_pkg::*;
(
  input  code_t key_code,
  input  logic  first_key,
  input  logic  store_mode,
  input  logic  seq_busy,
  output act_e  act,
  output code_t entry,
  output logic  uses_first
);
  always_comb begin
    act        = ACT_NONE;
    entry      = ENT_EMPTY;
    uses_first = 1'b1;
    if (is_dial_key(key_code)) begin
      act   = ACT_STORE;
      entry = key_code;
    end else begin
      unique case (key_code)
        KEY_RP: begin
          if (first_key) act = ACT_REDIAL;
          else begin
            act   = ACT_STORE;
            entry = ENT_PAUSE;
          end
        end
        KEY_TONE: begin
          act   = ACT_STORE;
          entry = ENT_TONE;
        end
        KEY_FLASH: begin
          if (store_mode) begin
            act   = ACT_STORE;
            entry = ENT_FLASH;
          end
        end
        default: begin
          uses_first = 1'b0;
          if (!seq_busy) act = ACT_CHECK;
        end
      endcase
    end
  end
endmodule

// File: rtl/redial_store.sv
module redial_store
  import redial_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_fresh,
  input  code_t         wr_code,
  input  logic [AW-1:0] rd_a_addr,
  output code_t         rd_a_code,
  input  logic [AW-1:0] rd_b_addr,
  output code_t         rd_b_code,
  output logic [CW-1:0] count,
  output logic          ovf
);
  code_t           slot_q [DEPTH];
  logic [CW-1:0]   count_q;
  logic            ovf_q;
  logic [AW-1:0]   wr_idx;
  logic            do_write;
  logic            ovf_set;
  logic [DEPTH-1:0] slot_we;

  assign wr_idx   = wr_fresh ? '0 : AW'(count_q);
  assign do_write = wr_en && (wr_fresh || (count_q < CW'(DEPTH)));
  assign ovf_set  = wr_en && !wr_fresh && (count_q == CW'(DEPTH));

  for (genvar g = 0; g < DEPTH; g++) begin : g_we
    assign slot_we[g] = do_write && (wr_idx == AW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= ENT_EMPTY;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (slot_we[i]) slot_q[i] <= wr_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (do_write) count_q <= wr_fresh ? CW'(1) : count_q + CW'(1);
      if (wr_en && wr_fresh) ovf_q <= 1'b0;
      else if (ovf_set)      ovf_q <= 1'b1;
    end
  end

  function automatic code_t pick(input logic [AW-1:0] a, input logic [CW-1:0] n,
                                 input code_t v);
    return (CW'(a) < n) ? v : ENT_EMPTY;
  endfunction

  assign rd_a_code = pick(rd_a_addr, count_q, slot_q[rd_a_addr]);
  assign rd_b_code = pick(rd_b_addr, count_q, slot_q[rd_b_addr]);
  assign count     = count_q;
  assign ovf       = ovf_q;
endmodule

// File: rtl/redial_replay.sv
module redial_replay #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [CW-1:0] count,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] rd_addr
);
  logic          active_q;
  logic [AW-1:0] idx_q;
  logic          last;

  assign last = (CW'(idx_q) + CW'(1)) == count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (abort) begin
      active_q <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q && out_ready) begin
      if (last) active_q <= 1'b0;
      else      idx_q    <= idx_q + AW'(1);
    end
  end

  assign out_valid = active_q;
  assign rd_addr   = idx_q;
endmodule

// File: rtl/redial_check.sv
module redial_check #(
  parameter int GROUPS = 2,
  parameter int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter,
  input  logic          step,
  input  logic          quit,
  output logic          active,
  output logic [GW-1:0] group
);
  logic          active_q;
  logic [GW-1:0] group_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      group_q  <= '0;
    end else if (quit) begin
      active_q <= 1'b0;
      group_q  <= '0;
    end else if (enter) begin
      active_q <= 1'b1;
      group_q  <= '0;
    end else if (step && active_q) begin
      if (group_q == GW'(GROUPS - 1)) begin
        active_q <= 1'b0;
        group_q  <= '0;
      end else begin
        group_q <= group_q + GW'(1);
      end
    end
  end

  assign active = active_q;
  assign group  = group_q;
endmodule

// File: rtl/redial_mem_ctrl.sv
module redial_mem_ctrl
  import redial_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int GROUP_SZ = 16,
  parameter int GROUPS   = DEPTH / GROUP_SZ,
  parameter int GW       = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  parameter int IW       = $clog2(GROUP_SZ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          off_hook,
  input  logic          seq_busy,
  input  logic          store_mode,
  input  logic          key_valid,
  input  logic [3:0]    key_code,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [3:0]    out_code,
  output logic          chk_active,
  output logic [GW-1:0] chk_group,
  input  logic [IW-1:0] disp_idx,
  output logic [3:0]    disp_code
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          hook_q, hook_rise, key_ok, normal_key;
  logic          first_q, fresh_q;
  act_e          act;
  code_t         entry;
  logic          uses_first;
  logic          store_wr, store_fresh, replay_start, chk_enter, chk_step;
  logic [CW-1:0] count;
  logic          ovf;
  logic [AW-1:0] rp_addr, dp_addr;

  function automatic logic [AW-1:0] disp_addr(input logic [GW-1:0] g,
                                               input logic [IW-1:0] i);
    return AW'(int'(g) * GROUP_SZ + int'(i));
  endfunction

  assign hook_rise    = off_hook && !hook_q;
  assign key_ok       = key_valid && off_hook && hook_q && !out_valid;
  assign normal_key   = key_ok && !chk_active;
  assign store_wr     = normal_key && (act == ACT_STORE);
  assign store_fresh  = fresh_q;
  assign replay_start = normal_key && (act == ACT_REDIAL) && (count != '0) && !ovf;
  assign chk_enter    = normal_key && (act == ACT_CHECK);
  assign chk_step     = key_ok && chk_active;
  assign dp_addr      = disp_addr(chk_group, disp_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hook_q  <= 1'b0;
      first_q <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      hook_q <= off_hook;
      if (hook_rise) begin
        first_q <= 1'b1;
        fresh_q <= 1'b1;
      end else begin
        if (normal_key && uses_first) first_q <= 1'b0;
        if (store_wr) fresh_q <= 1'b0;
      end
    end
  end

  redial_keyclass u_cls (
    .key_code  (key_code),
    .first_key (first_q),
    .store_mode(store_mode),
    .seq_busy  (seq_busy),
    .act       (act),
    .entry     (entry),
    .uses_first(uses_first)
  );

  redial_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (store_wr),
    .wr_fresh (store_fresh),
    .wr_code  (entry),
    .rd_a_addr(rp_addr),
    .rd_a_code(out_code),
    .rd_b_addr(dp_addr),
    .rd_b_code(disp_code),
    .count    (count),
    .ovf      (ovf)
  );

  redial_replay #(.DEPTH(DEPTH)) u_replay (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (replay_start),
    .abort    (!off_hook),
    .count    (count),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .rd_addr  (rp_addr)
  );

  redial_check #(.GROUPS(GROUPS)) u_check (
    .clk   (clk),
    .rst_n (rst_n),
    .enter (chk_enter),
    .step  (chk_step),
    .quit  (!off_hook),
    .active(chk_active),
    .group (chk_group)
  );
endmodule

// File: rtl/redial_mem_ctrl_sva.sv
module redial_mem_ctrl_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       off_hook,
  input logic       key_valid,
  input logic [3:0] key_code,
  input logic       out_valid,
  input logic       out_ready,
  input logic [3:0] out_code,
  input logic       chk_active,
  input logic       replay_start,
  input logic       store_wr,
  input logic       store_fresh,
  input logic       ovf
);
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && off_hook |=> out_valid && $stable(out_code));

  a_r13_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !off_hook |=> !out_valid);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(chk_active && out_valid));

  a_r7_no_redial_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> !replay_start);

  a_r6_fresh_clears: assert property (@(posedge clk) disable iff (!rst_n)
    store_wr && store_fresh |=> !ovf);

  a_r3_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    replay_start |-> key_valid && key_code == 4'd12);

  a_r3_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    replay_start |=> out_valid);

  a_r9_onhook_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !off_hook |-> !replay_start && !store_wr);
endmodule

bind redial_mem_ctrl redial_mem_ctrl_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .off_hook    (off_hook),
  .key_valid   (key_valid),
  .key_code    (key_code),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_code    (out_code),
  .chk_active  (chk_active),
  .replay_start(replay_start),
  .store_wr    (store_wr),
  .store_fresh (store_fresh),
  .ovf         (ovf)
);

// File: tb/tb_redial_mem_ctrl.sv
module tb_redial_mem_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       off_hook = 1'b0, seq_busy = 1'b0, store_mode = 1'b0;
  logic       key_valid = 1'b0;
  logic [3:0] key_code = 4'd0;
  logic       out_valid, out_ready = 1'b0;
  logic [3:0] out_code;
  logic       chk_active;
  logic [0:0] chk_group;
  logic [3:0] disp_idx = 4'd0;
  logic [3:0] disp_code;

  int checks = 0, errors = 0;
  int mdl[32];
  int mcnt = 0, movf = 0, mfresh = 0;

  always #5 clk = ~clk;

  redial_mem_ctrl dut (
    .clk(clk), .rst_n(rst_n), .off_hook(off_hook), .seq_busy(seq_busy),
    .store_mode(store_mode), .key_valid(key_valid), .key_code(key_code),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
    .chk_active(chk_active), .chk_group(chk_group), .disp_idx(disp_idx),
    .disp_code(disp_code)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic m_clear();
    for (int i = 0; i < 32; i++) mdl[i] = 15;
    mcnt = 0; movf = 0;
  endtask

  task automatic m_store(input int c);
    if (mfresh != 0) begin m_clear(); mfresh = 0; end
    if (mcnt < 32) begin mdl[mcnt] = c; mcnt++; end
    else movf = 1;
  endtask

  task automatic press(input int c);
    @(negedge clk);
    key_valid = 1'b1; key_code = 4'(c);
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic hook(input bit up);
    @(negedge clk);
    off_hook = up;
    if (up) mfresh = 1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic disp_group(input int g, input string req);
    for (int i = 0; i < 16; i++) begin
      int a;
      a = g * 16 + i;
      disp_idx = 4'(i); #1;
      chk(int'(disp_code), (a < mcnt) ? mdl[a] : 15, req);
    end
  endtask

  task automatic drain(input int n_exp, input string req);
    int got = 0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      out_ready = (cyc % 3) != 1; #1;
      if (!out_valid) break;
      if (out_ready) begin
        chk(int'(out_code), mdl[got], req);
        got++;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(got, n_exp, req);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid, 0, "R1 out_valid");
    chk(chk_active, 0, "R1 chk_active");
    chk(chk_group, 0, "R1 chk_group");
    disp_group(0, "R1 empty display");

    // R2: dial keys and pulse-to-tone
    hook(1);
    foreach (mdl[i]) ;
    press(5); m_store(5);
    press(0); m_store(0);
    press(11); m_store(11);
    press(10); m_store(10);
    press(13); m_store(13);
    disp_group(0, "R2 stored order");
    // R4: later redial/pause key stores a pause
    press(12); m_store(12);
    disp_idx = 4'd5; #1; chk(disp_code, 12, "R4 pause entry");
    // R5: flash follows store_mode
    press(14);
    disp_idx = 4'd6; #1; chk(disp_code, 15, "R5 flash not stored");
    store_mode = 1'b1;
    press(14); m_store(14);
    store_mode = 1'b0;
    disp_idx = 4'd6; #1; chk(disp_code, 14, "R5 flash stored");
    // R10 / R9: on-hook keeps contents, keys ignored
    hook(0);
    press(7);
    disp_group(0, "R10 R9 on-hook");
    // R9: key in the off-hook rise cycle is ignored
    @(negedge clk);
    off_hook = 1'b1; key_valid = 1'b1; key_code = 4'd12; mfresh = 1;
    @(negedge clk); key_valid = 1'b0;
    chk(out_valid, 0, "R9 rise-cycle key");
    // R3: first key redial
    press(12);
    chk(out_valid, 1, "R3 replay start");
    chk(out_code, mdl[0], "R8 first entry");
    press(3);
    chk(out_valid, 1, "R8 stall hold");
    chk(out_code, mdl[0], "R8 stall code");
    drain(7, "R8 replay order");
    disp_group(0, "R9 key during replay");
    // R6: new number discards old contents
    press(9); m_store(9);
    disp_group(0, "R6 fresh start");

    // R7 boundary: exactly 32 entries still redial
    hook(0); hook(1);
    for (int i = 0; i < 32; i++) begin press((i * 7) % 12); m_store((i * 7) % 12); end
    hook(0); hook(1);
    press(12);
    drain(32, "R7 full buffer replay");

    // R7: 33 entries overflow
    hook(0); hook(1);
    for (int i = 0; i < 33; i++) begin press(i % 10); m_store(i % 10); end
    chk(movf, 1, "R7 model overflow");
    // R11: check mode
    seq_busy = 1'b1; press(15); seq_busy = 1'b0;
    chk(chk_active, 0, "R11 busy check ignored");
    press(15);
    chk(chk_active, 1, "R11 check entered");
    chk(chk_group, 0, "R11 group 0");
    disp_group(0, "R12 group 0 read");
    press(12);
    chk(chk_group, 1, "R11 group advance");
    chk(out_valid, 0, "R11 no redial in check");
    disp_group(1, "R12 group 1 read");
    press(5);
    chk(chk_active, 0, "R11 check exit");
    disp_group(0, "R11 check keys not stored");
    // R7 / R10: overflow survives on-hook, redial disabled
    hook(0); hook(1);
    press(12);
    repeat (3) @(negedge clk);
    chk(out_valid, 0, "R7 redial disabled");
    // R6: pause as first storing key clears overflow
    press(12); m_store(12);
    disp_group(0, "R6 pause restarts");
    hook(0); hook(1);
    press(12);
    chk(out_valid, 1, "R6 redial re-enabled");
    chk(out_code, 12, "R6 replay pause");
    // R13: on-hook ends replay
    @(negedge clk); off_hook = 1'b0;
    @(negedge clk);
    chk(out_valid, 0, "R13 abort");
    // R10: reset clears contents
    rst_n = 1'b0; m_clear();
    @(negedge clk); rst_n = 1'b1;
    disp_group(0, "R10 reset clears");
    hook(1);
    press(12);
    chk(out_valid, 0, "R10 no redial after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule